// File: doc/BRIEF.md
# Hexagonal Binary Cellular Logic Array

This block is a two-dimensional grid of identical one-bit processing cells laid out on a hexagonal lattice. The default grid has 12 rows of 16 cells. Every cell sees its own pattern bit and a single merged "incoming" bit. The incoming bit is the OR of the propagation bits of its six edge-sharing neighbours, a per-cell label bit, and a programmable border value that stands in for any neighbour position outside the grid. One shared 4-bit table maps the cell's (pattern, incoming) pair to its result bit. A second shared 4-bit table maps the same pair to the propagation bit it drives toward its neighbours.

Signals travel through chains of like cells, so one operation can find features that depend on connectivity. Examples are regions connected to the grid margin, regions connected to labelled cells, and edges against the background. The block models this travel as synchronous relaxation. A start pulse captures all inputs and clears every propagation bit. On each following clock, all propagation bits are recomputed from the captured inputs. The run finishes when a recomputation leaves them unchanged. It also finishes when an iteration limit is reached, which happens for tables that invert the incoming signal and so oscillate. When the run finishes, the result plane is registered and a one-cycle done pulse is raised.

Top module: `hex_cell_array`

## Requirements
- R1: After reset, `result` is all zero and `busy`, `done` and `no_conv` are low.
- R2: A cell's result bit is `func_res[{a0,an}]` and its propagation bit is `func_prop[{a0,an}]`. Here a0 is the cell's pattern bit, an is its incoming bit, and index 0..3 means (a0,an) = 00, 01, 10, 11. With `func_prop` = 0 and `border` = 0, `result` is the pointwise function of `pat_in` and `gate_in`. For example, `func_res` = 4'b1110 gives their OR and 4'b1000 gives their AND.
- R3: A cell's incoming bit is the OR of its six neighbours' propagation bits, its own `gate_in` bit, and `border` once for each missing neighbour.
- R4: Cell (r,c) has index r*COLS+c. Its neighbours are (r,c-1), (r,c+1), (r-1,c-1+k), (r-1,c+k), (r+1,c-1+k) and (r+1,c+k), where k = r mod 2. An interior cell therefore has exactly six neighbours.
- R5: A run starts with every propagation bit at 0 and recomputes all of them each clock. When a recomputation leaves them unchanged, the results of that settled state are registered. `done` then pulses for exactly one cycle, and `busy` is low again in that same cycle.
- R6: If the propagation bits are still changing after MAX_ITER recomputation cycles, the run ends anyway. The result then comes from the last state, and `no_conv` is high together with `done`.
- R7: A start pulse while `busy` is high is ignored. Changes to `pat_in`, `gate_in`, `func_res`, `func_prop` or `border` during a run do not affect that run.
- R8: With `border` = 1, cells on the grid edge receive 1 from their missing neighbours. A pass-through table then marks black cells adjacent to margin-connected white cells.
- R9: A `gate_in` bit of 1 makes that cell a propagation source. A black-passing table marks exactly the black cells connected to a labelled cell.
- R10: `result` holds its value except in the cycle that `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; inputs are captured on this edge |
| pat_in | input | ROWS*COLS | Pattern plane, one bit per cell (1 = black) |
| gate_in | input | ROWS*COLS | Label plane OR-ed into each cell's incoming bit |
| func_res | input | 4 | Result truth table, indexed by {a0,an} |
| func_prop | input | 4 | Propagation truth table, indexed by {a0,an} |
| border | input | 1 | Value seen from neighbour positions outside the grid |
| result | output | ROWS*COLS | Registered result plane of the last run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| no_conv | output | 1 | With done: the run hit the iteration limit |

## Verification
The bound checker watches the run protocol on every cycle:
- a run begins with cleared propagation bits;
- `done` is a single pulse that coincides with the end of `busy`;
- `no_conv` never appears without `done`;
- the iteration counter stays within its limit;
- `result` never moves outside a `done` cycle;
- a start pulse during a run leaves `busy` asserted.

Other properties depend on whole-grid data, and only the bench scenarios can show them. These are:
- the correctness of the result planes;
- the hexagonal neighbour layout, including the odd-row shift and edge cells;
- the effect of the border and label bits;
- the proof that a start pulse or input changes during a run leave its result untouched.

The bench checks these against its own relaxation model.

// File: rtl/hexarr_pkg.sv
package hexarr_pkg;

  // Index of neighbour d (0..5) of cell (r,c) on an offset-row hex grid,
  // or -1 when that position lies outside the grid.
  function automatic int nb_index(input int rows, input int cols,
                                  input int r, input int c, input int d);
    int shift;
    int nr;
    int nc;
    shift = r % 2;
    case (d)
      0:       begin nr = r;     nc = c - 1;         end
      1:       begin nr = r;     nc = c + 1;         end
      2:       begin nr = r - 1; nc = c - 1 + shift; end
      3:       begin nr = r - 1; nc = c + shift;     end
      4:       begin nr = r + 1; nc = c - 1 + shift; end
      default: begin nr = r + 1; nc = c + shift;     end
    endcase
    if (nr < 0 || nr >= rows || nc < 0 || nc >= cols) return -1;
    return nr * cols + nc;
  endfunction

  // Two-input truth table lookup, index {a0,an}.
  function automatic logic tt_pick(input logic [3:0] tt, input logic a0,
                                   input logic an);
    return tt[{a0, an}];
  endfunction

endpackage

// File: rtl/hex_an_net.sv
module hex_an_net #(
  parameter int ROWS = 12,
  parameter int COLS = 16,
  localparam int N = ROWS * COLS
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] gate,
  input  logic         border,
  output logic [N-1:0] an
);
  import hexarr_pkg::*;

  logic [N-1:0][5:0] term;

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    for (genvar d = 0; d < 6; d++) begin : g_dir
      localparam int NB = nb_index(ROWS, COLS, gi / COLS, gi % COLS, d);
      if (NB < 0) begin : g_edge
        assign term[gi][d] = border;
      end else begin : g_link
        assign term[gi][d] = prop[NB];
      end
    end
    assign an[gi] = gate[gi] | (|term[gi]);
  end

endmodule

// File: rtl/hex_cell_lane.sv
module hex_cell_lane #(
  parameter int N = 192
) (
  input  logic [N-1:0] a0,
  input  logic [N-1:0] an,
  input  logic [3:0]   func_res,
  input  logic [3:0]   func_prop,
  output logic [N-1:0] a1,
  output logic [N-1:0] prop_nxt
);
  import hexarr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign a1[i]       = tt_pick(func_res,  a0[i], an[i]);
    assign prop_nxt[i] = tt_pick(func_prop, a0[i], an[i]);
  end

endmodule

// File: rtl/hex_relax_ctrl.sv
module hex_relax_ctrl #(
  parameter int MAX_ITER = 192,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          settled,
  output logic          busy,
  output logic          load,
  output logic          finish,
  output logic          advance,
  output logic [IW-1:0] iter
);
  localparam logic [IW-1:0] LAST = IW'(MAX_ITER - 1);

  assign load    = start & ~busy;
  assign finish  = busy & (settled | (iter == LAST));
  assign advance = busy & ~finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      iter <= '0;
    end else if (load) begin
      busy <= 1'b1;
      iter <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      iter <= '0;
    end else if (advance) begin
      iter <= iter + 1'b1;
    end
  end

endmodule

// File: rtl/hex_cell_array.sv
module hex_cell_array #(
  parameter int ROWS = 12,
  parameter int COLS = 16,
  parameter int MAX_ITER = 192,
  localparam int N = ROWS * COLS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] pat_in,
  input  logic [N-1:0] gate_in,
  input  logic [3:0]   func_res,
  input  logic [3:0]   func_prop,
  input  logic         border,
  output logic [N-1:0] result,
  output logic         busy,
  output logic         done,
  output logic         no_conv
);
  localparam int IW = $clog2(MAX_ITER + 1);

  logic [N-1:0] pat_q, gate_q, prop_q;
  logic [3:0]   fres_q, fprop_q;
  logic         border_q;

  // named internal events for the checker
  logic [N-1:0] an_now, a1_now, prop_nxt;
  logic         settled, load, finish, advance;
  logic [IW-1:0] iter_q;

  hex_an_net #(.ROWS(ROWS), .COLS(COLS)) u_an (
    .prop   (prop_q),
    .gate   (gate_q),
    .border (border_q),
    .an     (an_now)
  );

  hex_cell_lane #(.N(N)) u_lane (
    .a0        (pat_q),
    .an        (an_now),
    .func_res  (fres_q),
    .func_prop (fprop_q),
    .a1        (a1_now),
    .prop_nxt  (prop_nxt)
  );

  assign settled = (prop_nxt == prop_q);

  hex_relax_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .settled (settled),
    .busy    (busy),
    .load    (load),
    .finish  (finish),
    .advance (advance),
    .iter    (iter_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q    <= '0;
      gate_q   <= '0;
      fres_q   <= '0;
      fprop_q  <= '0;
      border_q <= 1'b0;
      prop_q   <= '0;
    end else if (load) begin
      pat_q    <= pat_in;
      gate_q   <= gate_in;
      fres_q   <= func_res;
      fprop_q  <= func_prop;
      border_q <= border;
      prop_q   <= '0;
    end else if (advance) begin
      prop_q   <= prop_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      done    <= 1'b0;
      no_conv <= 1'b0;
    end else begin
      done    <= finish;
      no_conv <= finish & ~settled;
      if (finish) result <= a1_now;
    end
  end

endmodule

// File: rtl/hex_cell_array_chk.sv
module hex_cell_array_chk #(
  parameter int N = 192,
  parameter int MAX_ITER = 192,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          no_conv,
  input logic [N-1:0]  result,
  input logic [N-1:0]  prop_q,
  input logic [IW-1:0] iter_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R5
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R5
  AST_PROP_CLEAR_AT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (prop_q == '0));  // R5
  AST_NOCONV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    no_conv |-> done);  // R6
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q < IW'(MAX_ITER));  // R6
  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && iter_q != IW'(MAX_ITER - 1)) |=> busy);  // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));  // R10
endmodule

bind hex_cell_array hex_cell_array_chk #(
  .N(N), .MAX_ITER(MAX_ITER), .IW(IW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .no_conv (no_conv),
  .result  (result),
  .prop_q  (prop_q),
  .iter_q  (iter_q)
);

// File: tb/sim_hex_cell_array.sv
`timescale 1ns/1ps
module sim_hex_cell_array;
  localparam int ROWS = 12;
  localparam int COLS = 16;
  localparam int N = ROWS * COLS;
  localparam int MAXI = 192;

  typedef struct {
    logic [N-1:0] res;
    logic         nc;
    string        tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [N-1:0] pat_in = '0, gate_in = '0;
  logic [3:0] func_res = '0, func_prop = '0;
  logic border = 0;
  logic [N-1:0] result;
  logic busy, done, no_conv;

  int checks = 0;
  int errors = 0;
  int completions = 0;
  exp_t sb[$];
  logic [N-1:0] last_res;

  always #5 clk = ~clk;

  hex_cell_array #(.ROWS(ROWS), .COLS(COLS), .MAX_ITER(MAXI)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_in(pat_in),
    .gate_in(gate_in), .func_res(func_res), .func_prop(func_prop),
    .border(border), .result(result), .busy(busy), .done(done),
    .no_conv(no_conv)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int idx(input int r, input int c);
    return r * COLS + c;
  endfunction

  // bench's own incoming-bit computation
  function automatic logic m_an(input logic [N-1:0] p, input logic [N-1:0] g,
                                input logic b, input int r, input int c);
    logic acc;
    acc = g[idx(r, c)];
    for (int k = 0; k < 6; k++) begin
      int dr, dc, rr, cc;
      if (k < 2) begin dr = 0; dc = (k == 0) ? -1 : 1; end
      else begin
        dr = (k < 4) ? -1 : 1;
        dc = ((k % 2) == 0) ? -1 : 0;
        if ((r % 2) == 1) dc = dc + 1;
      end
      rr = r + dr; cc = c + dc;
      if (rr < 0 || rr >= ROWS || cc < 0 || cc >= COLS) acc = acc | b;
      else acc = acc | p[idx(rr, cc)];
    end
    return acc;
  endfunction

  task automatic model(input logic [N-1:0] pat, input logic [N-1:0] g,
                       input logic [3:0] fr, input logic [3:0] fp,
                       input logic b, output logic [N-1:0] res,
                       output logic nc);
    logic [N-1:0] p, nx, a1;
    p = '0; nc = 0; res = '0;
    for (int it = 0; it < MAXI; it++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          logic an;
          int sel;
          an = m_an(p, g, b, r, c);
          sel = pat[idx(r, c)] * 2 + int'(an);
          nx[idx(r, c)] = fp[sel];
          a1[idx(r, c)] = fr[sel];
        end
      if (nx == p) begin res = a1; nc = 0; break; end
      if (it == MAXI - 1) begin res = a1; nc = 1; break; end
      p = nx;
    end
  endtask

  // driver: predicts, queues, starts, waits for completion
  task automatic run_op(input logic [N-1:0] pat, input logic [N-1:0] g,
                        input logic [3:0] fr, input logic [3:0] fp,
                        input logic b, input string tag);
    exp_t e;
    int target;
    model(pat, g, fr, fp, b, e.res, e.nc);
    e.tag = tag;
    sb.push_back(e);
    target = completions + 1;
    @(negedge clk);
    pat_in = pat; gate_in = g; func_res = fr; func_prop = fp; border = b;
    start = 1;
    @(negedge clk);
    start = 0;
    while (completions < target) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(0, "R7", "unexpected done", result, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, e.tag, "result", result, e.res);
        chk(no_conv == e.nc, e.tag, "no_conv", N'(no_conv), N'(e.nc));
      end
      last_res = result;
      completions++;
    end
  end

  initial begin
    #(200000 * 10);
    chk(0, "WDOG", "watchdog expired", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] pa, pb, lab;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(result == '0 && !busy && !done && !no_conv, "R1", "reset state",
        result, '0);
    rst_n = 1;
    @(negedge clk);

    // R2 pointwise OR and AND of two planes
    pa = '0; pb = '0;
    for (int i = 0; i < N; i++) begin pa[i] = (i % 3 == 0); pb[i] = (i % 5 == 0); end
    run_op(pa, pb, 4'b1110, 4'b0000, 1'b0, "R2");
    chk(result == (pa | pb), "R2", "OR plane", result, pa | pb);
    run_op(pa, pb, 4'b1000, 4'b0000, 1'b0, "R2");
    chk(result == (pa & pb), "R2", "AND plane", result, pa & pb);

    // R3 black cells with a white neighbour: lone black cell in all-white
    pa = '0; pa[idx(6, 7)] = 1;
    run_op(pa, '0, 4'b1000, 4'b0011, 1'b0, "R3");
    chk(result == pa, "R3", "lone black edge", result, pa);

    // R4 neighbour sets, even and odd rows, interior and corner
    pa = '0; pa[idx(4, 5)] = 1;
    run_op(pa, '0, 4'b0010, 4'b1100, 1'b0, "R4");
    chk($countones(result) == 6 && result[idx(3,4)] && result[idx(3,5)]
        && result[idx(5,4)] && result[idx(5,5)], "R4", "even row set",
        result, '0);
    pa = '0; pa[idx(5, 5)] = 1;
    run_op(pa, '0, 4'b0010, 4'b1100, 1'b0, "R4");
    chk($countones(result) == 6 && result[idx(4,6)] && result[idx(6,6)]
        && result[idx(4,5)] && result[idx(6,5)], "R4", "odd row set",
        result, '0);
    pa = '0; pa[idx(0, 0)] = 1;
    run_op(pa, '0, 4'b0010, 4'b1100, 1'b0, "R4");
    chk($countones(result) == 2, "R4", "corner set", result, '0);

    // R8 outer edge with border 1 on a solid block
    pa = '0;
    for (int r = 3; r <= 7; r++) for (int c = 5; c <= 9; c++) pa[idx(r, c)] = 1;
    run_op(pa, '0, 4'b1000, 4'b0010, 1'b1, "R8");
    chk(result[idx(5, 7)] == 0 && result[idx(3, 6)] == 1, "R8",
        "core vs edge", result, '0);
    run_op(pa, '0, 4'b1000, 4'b0010, 1'b0, "R8");
    chk(result == '0, "R8", "border 0 blocks", result, '0);

    // R9 labelled region selection
    pa = '0; lab = '0;
    for (int c = 2; c <= 4; c++) pa[idx(5, c)] = 1;
    for (int c = 10; c <= 12; c++) pa[idx(5, c)] = 1;
    lab[idx(5, 3)] = 1;
    run_op(pa, lab, 4'b1000, 4'b1000, 1'b0, "R9");
    pb = '0; for (int c = 2; c <= 4; c++) pb[idx(5, c)] = 1;
    chk(result == pb, "R9", "labelled blob only", result, pb);

    // R6 + R7: oscillating table, start pulse and input change mid-run
    begin
      exp_t e;
      int target;
      model('0, '0, 4'b1111, 4'b0101, 1'b0, e.res, e.nc);
      e.tag = "R6";
      sb.push_back(e);
      target = completions + 1;
      @(negedge clk);
      pat_in = '0; gate_in = '0; func_res = 4'b1111; func_prop = 4'b0101;
      border = 0; start = 1;
      @(negedge clk);
      start = 0;
      repeat (10) @(negedge clk);
      pat_in = '1; func_res = 4'b0000; func_prop = 4'b0000; start = 1;
      @(negedge clk);
      start = 0;
      while (completions < target) @(negedge clk);
      chk(e.nc == 1, "R6", "model predicts no convergence", N'(e.nc), N'(1));
      chk(result == '1, "R7", "mid-run changes ignored", result, '1);
      repeat (5) @(negedge clk);
      chk(completions == target && !busy, "R7", "no second run",
          N'(completions), N'(target));
    end

    // R10 result holds between runs
    repeat (4) @(negedge clk);
    chk(result == last_res, "R10", "result held", result, last_res);

    // R5 random patterns with connectivity tables
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < N; i++) begin
        pa[i] = ($urandom % 3) != 0;
        pb[i] = ($urandom % 40) == 0;
      end
      run_op(pa, pb, 4'($urandom), (t % 2) ? 4'b1000 : 4'b0010,
             1'(t % 3 == 0), "R5");
    end
    chk(sb.size() == 0, "R5", "scoreboard drained", N'(sb.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule